// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the ROM-function stage of a single-wire bus slave. It sits on top of a bit-level time-slot engine. That engine hands it every bit the master writes (`rx_valid_i`/`rx_bit_i`) and asks it for a bit whenever the master opens a read slot (`tx_req_i`, answered on `tx_bit_o`). A value of 1 on `tx_bit_o` means the line is left released. The block also gets a bus-reset indication from the engine.

The block holds a 64-bit identity. It is built from a family code, a 48-bit serial number and a CRC-8, all set by parameters, and the CRC is computed inside the block. After each bus reset the block takes in an 8-bit ROM command and runs one of these flows:

- read out the identity,
- compare against an identity sent by the master,
- skip addressing,
- bitwise search arbitration,
- a search that the device joins only while an interrupt is pending.

A successful flow raises `grant_o`, which opens the memory-function stage. A failed or unknown flow leaves the block silent until the next bus reset.

Top module: `owr_rom_layer`

## Requirements
- R1: The identity is sent least significant bit first. Bits 7:0 are the family code (default 04h), bits 55:8 are the 48-bit serial number and bits 63:56 are the CRC.
- R2: The CRC is computed over identity bits 0 to 55, taken LSB first, with polynomial x^8+x^5+x^4+1 and a register cleared to zero. Feeding all 64 identity bits through the same generator leaves zero.
- R3: A ROM command is the first 8 bits written after a bus reset, least significant bit first.
- R4: Command 33h answers the next 64 read slots with identity bits 0 to 63 in order. `grant_o` rises after the 64th slot.
- R5: Command CCh raises `grant_o` in the cycle after its 8th bit.
- R6: Command 55h compares the next 64 written bits with the identity. Only a full match raises `grant_o`. On the first mismatch the block goes idle.
- R7: Command F0h runs a search of 64 steps. Each step answers a read slot with the identity bit, then a read slot with its complement, then takes one written bit. A written bit that differs from the identity bit sends the block idle. Completing all 64 steps raises `grant_o`.
- R8: Command ECh runs the R7 search only if `irq_pending_i` is high when the command completes. Otherwise the block goes idle.
- R9: Any other command code sends the block idle.
- R10: When idle, the block answers every read slot with 1, ignores written bits and keeps `grant_o` low until a bus reset.
- R11: `bus_reset_i` aborts any flow in any state. It clears `grant_o`, and the next written bits form a new command.
- R12: After `rst_ni` the block is idle and waits for the first bus reset. Once raised, `grant_o` stays high, whatever bits or slots follow, until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: the bit engine saw a bus reset |
| rx_valid_i | input | 1 | One-cycle pulse: a written bit is available |
| rx_bit_i | input | 1 | Value of the written bit |
| tx_req_i | input | 1 | One-cycle pulse: a read slot consumes `tx_bit_o` |
| irq_pending_i | input | 1 | An unacknowledged interrupt is pending |
| tx_bit_o | output | 1 | Bit for the current read slot (1 = line released) |
| grant_o | output | 1 | Memory-function access granted |

## Verification
The bench plays out a whole search pass. It checks each bit against its complement and then makes the device lose at one step. A design that skips the complement slot, or keeps answering after losing, would drive the line and corrupt arbitration among other slaves.

It also checks these cases:
- A match with a single flipped serial bit must not grant access.
- A conditional search with no interrupt pending must stay silent.
- An unknown command must not grant access.
- A bus reset in the middle of a read-out must return the block to command decode. A design without the abort would stay stuck in the old flow.

The CRC is checked against a known identity value and against the zero-residue property.

// File: rtl/owr_pkg.sv
package owr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_GRANT
  } owr_state_e;

  localparam logic [7:0] CMD_READ    = 8'h33;
  localparam logic [7:0] CMD_MATCH   = 8'h55;
  localparam logic [7:0] CMD_SKIP    = 8'hCC;
  localparam logic [7:0] CMD_SEARCH  = 8'hF0;
  localparam logic [7:0] CMD_CSEARCH = 8'hEC;
endpackage

// File: rtl/owr_id_rom.sv
module owr_id_rom #(
  parameter int unsigned FAM_W = 8,
  parameter int unsigned SER_W = 48,
  parameter int unsigned CRC_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h04,
  parameter logic [SER_W-1:0] SERIAL = '0,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C,
  localparam int unsigned DAT_W = FAM_W + SER_W,
  localparam int unsigned ID_W = DAT_W + CRC_W
) (
  output logic [ID_W-1:0] id_o
);
  logic [DAT_W-1:0] data;
  logic [CRC_W-1:0] crc;
  logic             fb;

  assign data = {SERIAL, FAMILY};

  // reflected shift register, LSB of data first
  always_comb begin
    crc = '0;
    fb  = 1'b0;
    for (int i = 0; i < int'(DAT_W); i++) begin
      fb  = crc[0] ^ data[i];
      crc = crc >> 1;
      if (fb) crc = crc ^ POLY_REFL;
    end
  end

  assign id_o = {crc, data};
endmodule

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
  parameter int unsigned CMD_W = 8,
  localparam int unsigned CNT_W = $clog2(CMD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  output logic             done_o,
  output logic [CMD_W-1:0] code_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en_i && rx_valid_i) begin
      sh_q  <= {rx_bit_i, sh_q[CMD_W-1:1]};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign done_o = en_i && rx_valid_i && (cnt_q == LAST);
  assign code_o = {rx_bit_i, sh_q[CMD_W-1:1]};
endmodule

// File: rtl/owr_search_step.sv
module owr_search_step (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       active_i,
  input  logic       id_bit_i,
  input  logic       tx_req_i,
  input  logic       rx_valid_i,
  input  logic       rx_bit_i,
  output logic       tx_bit_o,
  output logic       step_o,
  output logic       lose_o,
  output logic [1:0] phase_o
);
  localparam logic [1:0] PH_TRUE = 2'd0;
  localparam logic [1:0] PH_COMP = 2'd1;
  localparam logic [1:0] PH_PICK = 2'd2;

  logic [1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_TRUE;
    end else if (clear_i) begin
      phase_q <= PH_TRUE;
    end else if (active_i) begin
      unique case (phase_q)
        PH_TRUE: if (tx_req_i)   phase_q <= PH_COMP;
        PH_COMP: if (tx_req_i)   phase_q <= PH_PICK;
        PH_PICK: if (rx_valid_i) phase_q <= PH_TRUE;
        default:                 phase_q <= PH_TRUE;
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_TRUE: tx_bit_o = id_bit_i;
      PH_COMP: tx_bit_o = ~id_bit_i;
      default: tx_bit_o = 1'b1;
    endcase
  end

  assign step_o  = active_i && (phase_q == PH_PICK) && rx_valid_i && (rx_bit_i == id_bit_i);
  assign lose_o  = active_i && (phase_q == PH_PICK) && rx_valid_i && (rx_bit_i != id_bit_i);
  assign phase_o = phase_q;
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_pkg::*;
#(
  parameter int unsigned FAM_W = 8,
  parameter int unsigned SER_W = 48,
  parameter int unsigned CRC_W = 8,
  parameter int unsigned CMD_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h04,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_1234_5678,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic tx_req_i,
  input  logic irq_pending_i,
  output logic tx_bit_o,
  output logic grant_o
);
  localparam int unsigned ID_W  = FAM_W + SER_W + CRC_W;
  localparam int unsigned IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  owr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [ID_W-1:0]  id;
  logic             id_bit;
  logic             cmd_done;
  logic [CMD_W-1:0] cmd_code;
  logic             srch_tx, srch_step, srch_lose;
  logic [1:0]       srch_phase;

  owr_id_rom #(
    .FAM_W(FAM_W), .SER_W(SER_W), .CRC_W(CRC_W),
    .FAMILY(FAMILY), .SERIAL(SERIAL), .POLY_REFL(POLY_REFL)
  ) u_id (
    .id_o(id)
  );

  assign id_bit = id[idx_q];

  owr_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (bus_reset_i),
    .en_i      (state_q == ST_CMD),
    .rx_valid_i(rx_valid_i),
    .rx_bit_i  (rx_bit_i),
    .done_o    (cmd_done),
    .code_o    (cmd_code)
  );

  owr_search_step u_srch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (bus_reset_i || (state_q != ST_SEARCH)),
    .active_i  (state_q == ST_SEARCH),
    .id_bit_i  (id_bit),
    .tx_req_i  (tx_req_i),
    .rx_valid_i(rx_valid_i),
    .rx_bit_i  (rx_bit_i),
    .tx_bit_o  (srch_tx),
    .step_o    (srch_step),
    .lose_o    (srch_lose),
    .phase_o   (srch_phase)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_CMD: if (cmd_done) begin
        idx_d = '0;
        unique case (cmd_code)
          CMD_READ:    state_d = ST_READ;
          CMD_SKIP:    state_d = ST_GRANT;
          CMD_MATCH:   state_d = ST_MATCH;
          CMD_SEARCH:  state_d = ST_SEARCH;
          CMD_CSEARCH: state_d = irq_pending_i ? ST_SEARCH : ST_IDLE;
          default:     state_d = ST_IDLE;
        endcase
      end
      ST_READ: if (tx_req_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) state_d = ST_GRANT;
      end
      ST_MATCH: if (rx_valid_i) begin
        idx_d = idx_q + 1'b1;
        if (rx_bit_i != id_bit)     state_d = ST_IDLE;
        else if (idx_q == IDX_LAST) state_d = ST_GRANT;
      end
      ST_SEARCH: begin
        if (srch_lose) begin
          state_d = ST_IDLE;
        end else if (srch_step) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_d = ST_GRANT;
        end
      end
      default: ;
    endcase
    if (bus_reset_i) begin
      state_d = ST_CMD;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READ:   tx_bit_o = id_bit;
      ST_SEARCH: tx_bit_o = srch_tx;
      default:   tx_bit_o = 1'b1;
    endcase
  end

  assign grant_o = (state_q == ST_GRANT);
endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk
  import owr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_reset_i,
  input logic       tx_req_i,
  input logic       tx_bit_o,
  input logic       grant_o,
  input owr_state_e state_q,
  input logic [1:0] srch_phase
);
  logic last_tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_tx_q <= 1'b1;
    else if (tx_req_i) last_tx_q <= tx_bit_o;
  end

  AST_ABORT_TO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (state_q == ST_CMD) && !grant_o); // R11

  AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !bus_reset_i) |=> grant_o); // R12

  AST_GRANT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(state_q) inside {ST_CMD, ST_READ, ST_MATCH, ST_SEARCH}); // R5

  AST_IDLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && !bus_reset_i) |=> (state_q == ST_IDLE) && !grant_o); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> tx_bit_o); // R10

  AST_SEARCH_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SEARCH) && (srch_phase == 2'd1) && tx_req_i) |-> (tx_bit_o != last_tx_q)); // R7
endmodule

bind owr_rom_layer owr_rom_layer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_reset_i(bus_reset_i),
  .tx_req_i   (tx_req_i),
  .tx_bit_o   (tx_bit_o),
  .grant_o    (grant_o),
  .state_q    (state_q),
  .srch_phase (srch_phase)
);

// File: tb/owr_rom_layer_test.sv
module owr_rom_layer_test;
  localparam logic [7:0]  FAM = 8'h02;
  localparam logic [47:0] SER = 48'h0000_0001_B81C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0, irq = 1'b0;
  logic tx_bit, grant;
  int   checks = 0, errors = 0;
  logic done = 1'b0;
  logic [63:0] exp_id;

  always #2 clk = ~clk;

  owr_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .rx_valid_i(rx_valid),
    .rx_bit_i(rx_bit), .tx_req_i(tx_req), .irq_pending_i(irq),
    .tx_bit_o(tx_bit), .grant_o(grant)
  );

  function automatic logic [7:0] crc_over(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ v[i];
      c = {1'b0, c[7:1]};
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic wr_bit(input logic b);
    @(negedge clk); rx_bit = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic rd_bit(output logic b);
    @(negedge clk); b = tx_bit; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic t_power_on();
    logic b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant == 1'b0 && tx_bit == 1'b1, "R12 reset state", {62'd0, grant, tx_bit}, 64'd1);
    wr_byte(8'hCC);
    rd_bit(b);
    chk(grant == 1'b0 && b == 1'b1, "R12 no command before bus reset", {62'd0, grant, b}, 64'd1);
  endtask

  task automatic t_crc();
    chk(crc_over(exp_id, 56) == 8'hA2, "R2 crc known value", {56'd0, exp_id[63:56]}, 64'hA2);
    chk(crc_over(exp_id, 64) == 8'h00, "R2 crc residue", {56'd0, crc_over(exp_id, 64)}, 64'd0);
  endtask

  task automatic t_read();
    logic [63:0] got;
    logic b;
    pulse_reset();
    wr_byte(8'h33);
    chk(grant == 1'b0, "R4 no grant before read-out", {63'd0, grant}, 64'd0);
    for (int i = 0; i < 64; i++) begin
      rd_bit(b);
      got[i] = b;
    end
    chk(got == exp_id, "R1 R4 identity read-out", got, exp_id);
    chk(grant == 1'b1, "R4 grant after read", {63'd0, grant}, 64'd1);
    wr_byte(8'h00);
    rd_bit(b);
    chk(grant == 1'b1 && b == 1'b1, "R12 grant held", {62'd0, grant, b}, 64'd3);
    pulse_reset();
    chk(grant == 1'b0, "R11 bus reset clears grant", {63'd0, grant}, 64'd0);
  endtask

  task automatic t_skip();
    pulse_reset();
    for (int i = 0; i < 7; i++) wr_bit(i[0] ? 1'b0 : 1'b0);
    chk(grant == 1'b0, "R3 R5 no grant before 8th bit", {63'd0, grant}, 64'd0);
    pulse_reset();
    wr_byte(8'hCC);
    chk(grant == 1'b1, "R3 R5 skip grant", {63'd0, grant}, 64'd1);
  endtask

  task automatic t_match(input int flip, input logic exp_g, input string req);
    logic b;
    pulse_reset();
    wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_bit((i == flip) ? ~exp_id[i] : exp_id[i]);
    rd_bit(b);
    chk(grant == exp_g && b == 1'b1, req, {62'd0, grant, b}, {62'd0, exp_g, 1'b1});
  endtask

  task automatic t_search(input logic [7:0] cmd, input int lose_at, input logic exp_g, input string req);
    logic b, c;
    int bad = 0;
    pulse_reset();
    wr_byte(cmd);
    for (int i = 0; i < 64; i++) begin
      rd_bit(b);
      rd_bit(c);
      if (i == lose_at) begin
        chk(b == exp_id[i] && c == ~exp_id[i], {req, " pair at lose step"}, {62'd0, b, c}, {62'd0, exp_id[i], ~exp_id[i]});
        wr_bit(~exp_id[i]);
        rd_bit(b);
        rd_bit(c);
        chk(b && c, {req, " silent after lose"}, {62'd0, b, c}, 64'd3);
        break;
      end
      if (b != exp_id[i] || c != ~exp_id[i]) bad++;
      wr_bit(exp_id[i]);
    end
    chk(bad == 0, {req, " bit/complement pairs"}, 64'(bad), 64'd0);
    chk(grant == exp_g, {req, " grant"}, {63'd0, grant}, {63'd0, exp_g});
  endtask

  task automatic t_csearch_quiet();
    logic b, c;
    irq = 1'b0;
    pulse_reset();
    wr_byte(8'hEC);
    rd_bit(b);
    rd_bit(c);
    wr_bit(exp_id[0]);
    chk(b && c && !grant, "R8 conditional search without irq silent", {61'd0, grant, b, c}, 64'd3);
  endtask

  task automatic t_unknown();
    logic b;
    pulse_reset();
    wr_byte(8'hA5);
    rd_bit(b);
    wr_byte(8'hCC);
    chk(b && !grant, "R9 R10 unknown command idles", {62'd0, grant, b}, 64'd1);
  endtask

  task automatic t_abort();
    logic b;
    pulse_reset();
    wr_byte(8'h33);
    for (int i = 0; i < 20; i++) rd_bit(b);
    pulse_reset();
    wr_byte(8'hCC);
    chk(grant == 1'b1, "R11 abort mid read then skip", {63'd0, grant}, 64'd1);
    pulse_reset();
    wr_byte(8'h55);
    for (int i = 0; i < 10; i++) wr_bit(exp_id[i]);
    pulse_reset();
    wr_byte(8'hCC);
    chk(grant == 1'b1, "R11 abort mid match then skip", {63'd0, grant}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_id = {crc_over({8'h00, SER, FAM}, 56), SER, FAM};
    t_power_on();
    t_crc();
    t_read();
    t_skip();
    t_match(-1, 1'b1, "R6 match exact");
    t_match(40, 1'b0, "R6 match one bit flipped");
    t_search(8'hF0, -1, 1'b1, "R7 search full");
    t_search(8'hF0, 10, 1'b0, "R7 search lose");
    t_csearch_quiet();
    irq = 1'b1;
    t_search(8'hEC, -1, 1'b1, "R8 conditional search with irq");
    irq = 1'b0;
    t_unknown();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule